// File: doc/BRIEF.md
# Asynchronous Byte-Lane SRAM Controller

This block sits between a simple synchronous request bus inside a chip and an external asynchronous pseudo-static RAM. The RAM holds 16-bit words, 128K of them by default, and has active-low strobes for chip select, write, output and each byte lane. A requester presents a word address, write data, a read/write flag and a two-bit lane mask. The controller then drives the memory strobes in a fixed order. Each phase lasts a number of clock cycles set on configuration inputs.

The controller owns the direction of the shared data bus. It enables its drivers only for writes, and only after output enable has been high for at least one cycle. It keeps the write data on the bus for a programmable hold time after the write window closes. A read is controlled by chip enable: the address, lane enables and output enable are set up one cycle before chip enable falls. The data is captured on the last access cycle and returned with a one-cycle valid pulse. A request whose mask is zero is acknowledged without any memory cycle.

Top module: `psram_ctrl`

## Requirements
- R1: After reset, chip, write, output and both lane enables are high, the data drivers are off (`mem_dq_oe`=0) and `req_ready` is 1.
- R2: A write stores `req_wdata[7:0]` into memory lane 0 (data lines 7..0) when `req_mask[0]`=1, and stores `req_wdata[15:8]` into lane 1 (lines 15..8) when `req_mask[1]`=1. A lane whose mask bit is 0 keeps its old contents.
- R3: A read returns memory lane k on `rd_data` for each set mask bit k, and zero in every lane whose mask bit is clear. `rd_valid` and `ack` pulse together for one cycle, 1+A cycles after the accepting edge. Writes never raise `rd_valid`.
- R4: Chip enable is low for exactly A consecutive cycles per operation, where A = `cfg_access_cycles` and a value of 0 acts as 1. While chip enable is low, at least one lane enable is low.
- R5: After chip enable and write enable rise at the end of a write, the bus is still driven for exactly H = `cfg_hold_cycles` cycles. The write is acknowledged 1+A+H cycles after the accepting edge.
- R6: `mem_dq_oe` is never 1 while output enable is low, and `mem_dq_oe` rises only when output enable was high in the previous cycle.
- R7: Write enable is high whenever chip enable and output enable are both low, and the address does not change while chip enable is low.
- R8: `req_ready` is 0 in the cycle `ack` is high and returns to 1 in the next cycle. Between two operations, chip enable stays high for at least two cycles: one recovery cycle plus the setup cycle.
- R9: A request with `req_mask`=0 is acknowledged in the cycle after it is accepted. Chip enable stays high and `rd_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_access_cycles | input | CNT_W | Chip-enable low time in cycles (0 acts as 1) |
| cfg_hold_cycles | input | CNT_W | Write data hold after the write window closes |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; a request is taken when valid and ready are both high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_mask | input | LANES | Byte lane mask, bit k selects data lines 8k+7..8k |
| req_wdata | input | DATA_W | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rd_valid | output | 1 | One-cycle read data valid |
| rd_data | output | DATA_W | Read data, with unselected lanes set to zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | LANES | Lane enables, active low |
| mem_dq_o | output | DATA_W | Data toward the memory |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_i | input | DATA_W | Data from the memory |

## Verification
The hardest case to reach is a bus turnaround with no idle gap. A write must follow a read as soon as `req_ready` returns, so that the driver enable rises right after the read's output enable was low. The bench therefore presents every request in the first cycle `req_ready` is high. It interleaves read and write sweeps over every address and every lane mask, under several access/hold settings that include a zero hold and a zero access count. Monitors count the cycles with chip enable low and the cycles with the bus driven after the window closes. They also record every case of bus driving while output enable is low or was low one cycle before.

// File: rtl/psram_pkg.sv
package psram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACCESS,
        ST_HOLD,
        ST_RECOVER
    } seq_state_e;

endpackage

// File: rtl/psram_timer.sv
module psram_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             last
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/psram_lane_gate.sv
module psram_lane_gate #(
    parameter int LANES = 2
) (
    input  logic [LANES*8-1:0] din,
    input  logic [LANES-1:0]   sel,
    output logic [LANES*8-1:0] dout
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dout[g*8 +: 8] = sel[g] ? din[g*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/psram_seq.sv
module psram_seq
    import psram_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CNT_W-1:0]    cfg_access_cycles,
    input  logic [CNT_W-1:0]    cfg_hold_cycles,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W/8-1:0] req_mask,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                ack,
    output logic                rd_valid,
    output logic [DATA_W-1:0]   rd_data,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_ce_n,
    output logic                mem_we_n,
    output logic                mem_oe_n,
    output logic [DATA_W/8-1:0] mem_be_n,
    output logic [DATA_W-1:0]   mem_dq_o,
    output logic                mem_dq_oe,
    input  logic [DATA_W-1:0]   lane_rdata,
    output logic [DATA_W/8-1:0] lane_sel,
    output logic                tmr_load,
    output logic [CNT_W-1:0]    tmr_load_val,
    output logic                tmr_run,
    input  logic                tmr_last
);

    localparam int LANES = DATA_W / 8;

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  mask;
        logic              wr;
        logic [DATA_W-1:0] wdata;
        logic              ce_n;
        logic              we_n;
        logic              oe_n;
        logic [LANES-1:0]  be_n;
        logic              dq_oe;
        logic              ack;
        logic              rd_valid;
        logic [DATA_W-1:0] rdata;
    } seq_regs_t;

    localparam seq_regs_t RESET_VAL = '{
        st: ST_IDLE, addr: '0, mask: '0, wr: 1'b0, wdata: '0,
        ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, be_n: '1, dq_oe: 1'b0,
        ack: 1'b0, rd_valid: 1'b0, rdata: '0
    };

    seq_regs_t r_d, r_q;
    logic [CNT_W-1:0] access_m1;
    logic [CNT_W-1:0] hold_m1;

    assign access_m1 = (cfg_access_cycles == '0) ? '0 : cfg_access_cycles - CNT_W'(1);
    assign hold_m1   = cfg_hold_cycles - CNT_W'(1);

    always_comb begin
        r_d          = r_q;
        r_d.ack      = 1'b0;
        r_d.rd_valid = 1'b0;
        tmr_load     = 1'b0;
        tmr_load_val = '0;
        tmr_run      = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr  = req_addr;
                    r_d.mask  = req_mask;
                    r_d.wr    = req_write;
                    r_d.wdata = req_wdata;
                    if (req_mask == '0) begin
                        r_d.st  = ST_RECOVER;
                        r_d.ack = 1'b1;
                    end else begin
                        r_d.st    = ST_SETUP;
                        r_d.be_n  = ~req_mask;
                        r_d.we_n  = ~req_write;
                        r_d.oe_n  = req_write;
                        r_d.dq_oe = req_write;
                    end
                end
            end
            ST_SETUP: begin
                r_d.ce_n     = 1'b0;
                r_d.st       = ST_ACCESS;
                tmr_load     = 1'b1;
                tmr_load_val = access_m1;
            end
            ST_ACCESS: begin
                tmr_run = 1'b1;
                if (tmr_last) begin
                    r_d.ce_n = 1'b1;
                    r_d.we_n = 1'b1;
                    r_d.oe_n = 1'b1;
                    r_d.be_n = '1;
                    if (r_q.wr) begin
                        if (cfg_hold_cycles != '0) begin
                            r_d.st       = ST_HOLD;
                            tmr_load     = 1'b1;
                            tmr_load_val = hold_m1;
                        end else begin
                            r_d.dq_oe = 1'b0;
                            r_d.ack   = 1'b1;
                            r_d.st    = ST_RECOVER;
                        end
                    end else begin
                        r_d.rdata    = lane_rdata;
                        r_d.rd_valid = 1'b1;
                        r_d.ack      = 1'b1;
                        r_d.st       = ST_RECOVER;
                    end
                end
            end
            ST_HOLD: begin
                tmr_run = 1'b1;
                if (tmr_last) begin
                    r_d.dq_oe = 1'b0;
                    r_d.ack   = 1'b1;
                    r_d.st    = ST_RECOVER;
                end
            end
            ST_RECOVER: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d = RESET_VAL;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= RESET_VAL;
        else        r_q <= r_d;
    end

    assign req_ready = (r_q.st == ST_IDLE);
    assign ack       = r_q.ack;
    assign rd_valid  = r_q.rd_valid;
    assign rd_data   = r_q.rdata;
    assign mem_addr  = r_q.addr;
    assign mem_ce_n  = r_q.ce_n;
    assign mem_we_n  = r_q.we_n;
    assign mem_oe_n  = r_q.oe_n;
    assign mem_be_n  = r_q.be_n;
    assign mem_dq_o  = r_q.wdata;
    assign mem_dq_oe = r_q.dq_oe;
    assign lane_sel  = r_q.mask;

    assert_no_drive_oe_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    assert_turnaround_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> $past(mem_oe_n));

    assert_read_we_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !mem_oe_n) |-> mem_we_n);

    assert_addr_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

    assert_ce_needs_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> (mem_be_n != '1));

    assert_recovery_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ce_n) |=> mem_ce_n);

    assert_ack_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !req_ready);

    assert_empty_mask_noop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && (req_mask == '0)) |=> (ack && mem_ce_n && !rd_valid));

endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CNT_W-1:0]    cfg_access_cycles,
    input  logic [CNT_W-1:0]    cfg_hold_cycles,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W/8-1:0] req_mask,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                ack,
    output logic                rd_valid,
    output logic [DATA_W-1:0]   rd_data,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_ce_n,
    output logic                mem_we_n,
    output logic                mem_oe_n,
    output logic [DATA_W/8-1:0] mem_be_n,
    output logic [DATA_W-1:0]   mem_dq_o,
    output logic                mem_dq_oe,
    input  logic [DATA_W-1:0]   mem_dq_i
);

    localparam int LANES = DATA_W / 8;

    logic [DATA_W-1:0] lane_rdata;
    logic [LANES-1:0]  lane_sel;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_load_val;
    logic              tmr_run;
    logic              tmr_last;

    psram_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
        .clk               (clk),
        .rst_n             (rst_n),
        .cfg_access_cycles (cfg_access_cycles),
        .cfg_hold_cycles   (cfg_hold_cycles),
        .req_valid         (req_valid),
        .req_ready         (req_ready),
        .req_write         (req_write),
        .req_addr          (req_addr),
        .req_mask          (req_mask),
        .req_wdata         (req_wdata),
        .ack               (ack),
        .rd_valid          (rd_valid),
        .rd_data           (rd_data),
        .mem_addr          (mem_addr),
        .mem_ce_n          (mem_ce_n),
        .mem_we_n          (mem_we_n),
        .mem_oe_n          (mem_oe_n),
        .mem_be_n          (mem_be_n),
        .mem_dq_o          (mem_dq_o),
        .mem_dq_oe         (mem_dq_oe),
        .lane_rdata        (lane_rdata),
        .lane_sel          (lane_sel),
        .tmr_load          (tmr_load),
        .tmr_load_val      (tmr_load_val),
        .tmr_run           (tmr_run),
        .tmr_last          (tmr_last)
    );

    psram_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_load_val),
        .run      (tmr_run),
        .last     (tmr_last)
    );

    psram_lane_gate #(.LANES(LANES)) u_gate (
        .din  (mem_dq_i),
        .sel  (lane_sel),
        .dout (lane_rdata)
    );

endmodule

// File: tb/psram_ctrl_test.sv
`timescale 1ns/1ps
module psram_ctrl_test;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int CW = 4;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CW-1:0] cfg_acc = 4'd1;
    logic [CW-1:0] cfg_hold = 4'd0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0] req_mask = 2'b00;
    logic [DW-1:0] req_wdata = '0;
    logic ack, rd_valid;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] mem_addr;
    logic mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [1:0] mem_be_n;
    logic [DW-1:0] mem_dq_o, mem_dq_i;

    always #2 clk = ~clk;

    psram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_access_cycles(cfg_acc), .cfg_hold_cycles(cfg_hold),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_mask(req_mask), .req_wdata(req_wdata),
        .ack(ack), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    logic [DW-1:0] store [DEPTH];
    logic [DW-1:0] model [DEPTH];

    always_comb begin
        for (int l = 0; l < 2; l++) begin
            if (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_be_n[l])
                mem_dq_i[l*8 +: 8] = store[mem_addr][l*8 +: 8];
            else
                mem_dq_i[l*8 +: 8] = 8'hA5;
        end
    end

    always @(posedge clk) begin
        if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
            for (int l = 0; l < 2; l++)
                if (!mem_be_n[l]) store[mem_addr][l*8 +: 8] <= mem_dq_o[l*8 +: 8];
        end
    end

    int checks = 0;
    int fails = 0;
    int ce_cnt = 0;
    int hold_cnt = 0;
    int gap = 100;
    int viol_r6 = 0;
    int viol_r7 = 0;
    int viol_r8 = 0;
    logic prev_oe_n = 1'b1;
    logic prev_dq_oe = 1'b0;
    logic prev_ce_n = 1'b1;
    logic [AW-1:0] prev_addr = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_ce_n) ce_cnt++;
            if (mem_dq_oe && mem_ce_n && mem_we_n) hold_cnt++;
            if (mem_dq_oe && !mem_oe_n) viol_r6++;
            if (mem_dq_oe && !prev_dq_oe && !prev_oe_n) viol_r6++;
            if (!mem_ce_n && !mem_oe_n && !mem_we_n) viol_r7++;
            if (!mem_ce_n && !prev_ce_n && (mem_addr != prev_addr)) viol_r7++;
            if (mem_ce_n) gap++;
            else begin
                if (prev_ce_n && gap < 2) viol_r8++;
                gap = 0;
            end
        end
        prev_oe_n  = mem_oe_n;
        prev_dq_oe = mem_dq_oe;
        prev_ce_n  = mem_ce_n;
        prev_addr  = mem_addr;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    function automatic logic [DW-1:0] lanes(input logic [DW-1:0] d, input logic [1:0] m);
        return {m[1] ? d[15:8] : 8'h00, m[0] ? d[7:0] : 8'h00};
    endfunction

    task automatic op(input logic wr, input int a, input logic [1:0] m, input logic [DW-1:0] d);
        int n;
        int eff_a;
        logic got_rv;
        logic [DW-1:0] got_rd;
        eff_a = (cfg_acc == 0) ? 1 : int'(cfg_acc);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_mask = m; req_wdata = d;
        ce_cnt = 0; hold_cnt = 0;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!ack && n < 60) begin @(negedge clk); n++; end
        got_rv = rd_valid; got_rd = rd_data;
        if (m == 2'b00) begin
            chk("R9 no-op latency", n, 0);
            chk("R9 no-op chip enable cycles", ce_cnt, 0);
            chk("R9 no-op rd_valid", {31'd0, got_rv}, 0);
        end else if (wr) begin
            chk("R5 write latency", n, 1 + eff_a + int'(cfg_hold));
            chk("R4 write chip enable cycles", ce_cnt, eff_a);
            chk("R5 hold cycles", hold_cnt, int'(cfg_hold));
            chk("R3 write rd_valid low", {31'd0, got_rv}, 0);
            for (int l = 0; l < 2; l++)
                if (m[l]) model[a][l*8 +: 8] = d[l*8 +: 8];
        end else begin
            chk("R3 read latency", n, 1 + eff_a);
            chk("R4 read chip enable cycles", ce_cnt, eff_a);
            chk("R3 rd_valid", {31'd0, got_rv}, 1);
            chk("R3 read data", {16'd0, got_rd}, {16'd0, lanes(model[a], m)});
        end
        chk("R8 ready low at ack", {31'd0, req_ready}, 0);
        @(negedge clk);
        chk("R8 ready after recovery", {31'd0, req_ready}, 1);
        chk("R8 ack one cycle", {31'd0, ack}, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin store[i] = '0; model[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 strobes high", {28'd0, mem_ce_n, mem_we_n, mem_oe_n, &mem_be_n}, 32'hF);
        chk("R1 drivers off", {31'd0, mem_dq_oe}, 0);
        chk("R1 ready", {31'd0, req_ready}, 1);

        for (int c = 0; c < 4; c++) begin
            case (c)
                0: begin cfg_acc = 4'd1; cfg_hold = 4'd0; end
                1: begin cfg_acc = 4'd4; cfg_hold = 4'd2; end
                2: begin cfg_acc = 4'd0; cfg_hold = 4'd1; end
                default: begin cfg_acc = 4'd3; cfg_hold = 4'd3; end
            endcase
            // R2: full-word writes of an address-derived pattern
            for (int a = 0; a < DEPTH; a++)
                op(1'b1, a, 2'b11, DW'((a * 257) ^ (c * 16'h1357)));
            // R2 / R9: lane-masked writes, mask 0 acts as no-op
            for (int a = 0; a < DEPTH; a++)
                op(1'b1, a, 2'(a + c), DW'(16'hC3C3 ^ (a * 97 + c)));
            // R3: reads under every mask, alternating with writes for turnaround
            for (int a = 0; a < DEPTH; a++) begin
                op(1'b0, a, 2'(a + c + 1), '0);
                if ((a % 8) == 3) op(1'b1, a, 2'b01, DW'(a + 16'h0A00));
                if ((a % 8) == 3) op(1'b0, a, 2'b11, '0);
            end
        end
        // R2: verify every lane held its value through masked writes
        for (int a = 0; a < DEPTH; a++)
            chk("R2 memory contents", {16'd0, store[a]}, {16'd0, model[a]});
        chk("R6 bus driven against output enable", viol_r6, 0);
        chk("R7 read strobes or address moved", viol_r7, 0);
        chk("R8 chip enable recovery gap", viol_r8, 0);
        summary();
    end

endmodule